// File: doc/BRIEF.md
# Stop-Level Power Sequencer

This block decides how a small microcontroller goes to sleep and how it comes back. The CPU raises a one-cycle stop request. The block checks the stop permission bit, reads a two-bit level select and the low-voltage-detector configuration, and then moves into one of three stop levels. If stop is not permitted, it raises an illegal-instruction reset pulse instead. Every power domain gets its own control output: clock enable, logic and RAM domain states, regulator standby, converter state, pad hold or pad reset, the periodic wake timer enable, and the oscillator enable.

The deepest level switches off the logic, the RAM and the clock generator, and puts the pads in their reset state. Only a reset pin or an active-low interrupt pin can wake it. Even then, it stays asleep until the supply-valid input confirms that the voltage has recovered, and it leaves through a power-on-reset pulse. The two lighter levels keep the RAM in standby and freeze the pads. They wake on an enabled interrupt, the reset pin, or a timer tick. The wake path first restores power and releases the pads with the clocks still gated, and re-enables the clocks one cycle later. The reason for each exit, or for an illegal-stop reset, is latched on a cause output.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A stop request with `stop_en` low leaves the block in run. In the next cycle `ill_rst` is high for exactly one cycle and `wake_cause` becomes 5.
- R2: Levels are selected by `lvl_sel`, where bit 1 is the primary bit. The value 11 selects level 1 and 10 selects level 2. Any value with bit 1 clear selects level 3. The chosen level's controls appear in the cycle after the request edge.
- R3: In run, `clk_en` and `osc_en` are high and every domain code is 0 (on). In every stop level, `clk_en` is low.
- R4: Domain codes are 0 for on, 1 for standby and 2 for off or disabled. Level 1 drives logic=2, RAM=2, converter=1, `reg_stby`=1, `pad_reset`=1, `pad_hold`=0, `osc_en`=0 and `lv_flag`=1.
- R5: Level 2 drives logic=2, RAM=1, converter=2, `reg_stby`=1, `pad_hold`=1, `pad_reset`=0 and `osc_en`=0. `pad_hold` and `pad_reset` are never high together.
- R6: Level 3 drives logic=1, RAM=1, converter=2, `reg_stby`=1 and `pad_hold`=1. `osc_en` equals `osc_keep`.
- R7: In any stop level, `rtw_en` equals `rtw_cfg`. In run and during wake, `rtw_en` is low.
- R8: When both `lvd_en` and `lvd_stop_en` are high, a request for level 1 or level 2 enters level 3 instead. When either bit is low, the selected level is kept.
- R9: Level 1 reacts only to `reset_pin_n` low or `irq_pin` low, whatever `irq_pol`, `irq_en` and `rtw_tick` are. Such an event is remembered, and the exit happens only once `supply_ok` is high.
- R10: The exit from level 1 raises `por_rst` for exactly one cycle, in the first wake cycle, and sets `wake_cause` to 1.
- R11: Levels 2 and 3 wake on `reset_pin_n` low (cause 3), on `irq_pin` equal to `irq_pol` while `irq_en` is high (cause 2), or on `rtw_tick` while `rtw_cfg` is high (cause 4). The priority order is reset pin, then interrupt, then timer. An interrupt with `irq_en` low has no effect.
- R12: Every exit passes through one wake cycle in which all domains are on and the pads are released while `clk_en` stays low. Run with `clk_en` high follows in the next cycle.
- R13: A stop request that arrives while the block is not in run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| stop_en | input | 1 | Permission for stop; when low a request is illegal |
| lvl_sel | input | 2 | Stop level select, bit 1 primary |
| lvd_en | input | 1 | Low-voltage detector enable |
| lvd_stop_en | input | 1 | Low-voltage detector kept active in stop |
| rtw_cfg | input | 1 | Periodic wake timer enabled in stop |
| osc_keep | input | 1 | Keep the oscillator running in level 3 |
| irq_en | input | 1 | Interrupt wake enable for levels 2 and 3 |
| irq_pol | input | 1 | Active level of the interrupt pin in levels 2 and 3 |
| irq_pin | input | 1 | Interrupt pin |
| reset_pin_n | input | 1 | Reset pin, active low |
| rtw_tick | input | 1 | Periodic wake timer expiry |
| supply_ok | input | 1 | Supply above the re-arm threshold |
| clk_en | output | 1 | Enable for all internal clocks |
| logic_dom | output | 2 | Logic domain state code |
| ram_dom | output | 2 | RAM domain state code |
| reg_stby | output | 1 | Regulator standby |
| conv_dom | output | 2 | Converter state code |
| pad_hold | output | 1 | Freeze pad states |
| pad_reset | output | 1 | Force pads to reset state |
| rtw_en | output | 1 | Periodic wake timer enable |
| osc_en | output | 1 | Oscillator / clock generator enable |
| lv_flag | output | 1 | Internal low-voltage flag |
| ill_rst | output | 1 | Illegal-stop reset pulse |
| por_rst | output | 1 | Power-on-reset pulse on level 1 exit |
| wake_cause | output | 3 | Latched cause of the last exit or illegal stop |

## Verification
Some properties are checked on every cycle. Clocks stay gated whenever any domain is down or the pads are held. Hold and pad reset never overlap. Clocks come back only after a cycle with everything powered and released. An illegal pulse only follows a refused request, lasts one cycle and is traced back to that request. Level 1 is left only with a valid supply, and the power-on pulse only comes out of it. A deep level is never entered while the detector is active in stop. The bench scenarios cover the rest: the exact domain encoding of each level, the level decode for all select values, wake priority and causes, ignored interrupts and requests, and the memory of a level 1 wake event while the supply is still low.

// File: rtl/stop_ctl_pkg.sv
package stop_ctl_pkg;

    localparam int CAUSE_W = 3;
    localparam int DOM_W   = 2;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_STOP1 = 3'd1,
        ST_STOP2 = 3'd2,
        ST_STOP3 = 3'd3,
        ST_WAKE  = 3'd4
    } pm_state_e;

    typedef enum logic [DOM_W-1:0] {
        DOM_ON   = 2'd0,
        DOM_STBY = 2'd1,
        DOM_OFF  = 2'd2
    } dom_e;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 3'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_POR   = 3'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_IRQ   = 3'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_PIN   = 3'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_TIMER = 3'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_ILL   = 3'd5;

    typedef struct packed {
        logic clk_en;
        dom_e logic_dom;
        dom_e ram_dom;
        logic reg_stby;
        dom_e conv_dom;
        logic pad_hold;
        logic pad_reset;
        logic osc_en;
        logic lv_flag;
    } dom_ctl_t;

    typedef struct packed {
        pm_state_e            state;
        logic                 pend;
        logic                 ill_pulse;
        logic                 por_pulse;
        logic [CAUSE_W-1:0]   cause;
    } ctl_regs_t;

endpackage

// File: rtl/stop_level_select.sv
module stop_level_select
    import stop_ctl_pkg::*;
(
    input  logic       stop_en_i,
    input  logic [1:0] sel_i,
    input  logic       lvd_en_i,
    input  logic       lvd_stop_en_i,
    output logic       illegal_o,
    output pm_state_e  target_o
);
    logic lvd_active;
    pm_state_e picked;

    assign lvd_active = lvd_en_i && lvd_stop_en_i;
    assign illegal_o  = !stop_en_i;

    always_comb begin
        if (sel_i[1] && sel_i[0]) begin
            picked = ST_STOP1;
        end else if (sel_i[1]) begin
            picked = ST_STOP2;
        end else begin
            picked = ST_STOP3;
        end
        // deep levels need the detector idle in stop
        if (lvd_active && (picked != ST_STOP3)) begin
            target_o = ST_STOP3;
        end else begin
            target_o = picked;
        end
    end
endmodule

// File: rtl/stop_wake_detect.sv
module stop_wake_detect
    import stop_ctl_pkg::*;
(
    input  pm_state_e           state_i,
    input  logic                pend_i,
    input  logic                reset_pin_n_i,
    input  logic                irq_pin_i,
    input  logic                irq_pol_i,
    input  logic                irq_en_i,
    input  logic                rtw_tick_i,
    input  logic                rtw_cfg_i,
    input  logic                supply_ok_i,
    output logic                wake_o,
    output logic                pend_o,
    output logic [CAUSE_W-1:0]  cause_o
);
    logic deep_hit;
    logic pin_hit;
    logic irq_hit;
    logic tmr_hit;

    assign deep_hit = pend_i || !reset_pin_n_i || !irq_pin_i;
    assign pin_hit  = !reset_pin_n_i;
    assign irq_hit  = irq_en_i && (irq_pin_i == irq_pol_i);
    assign tmr_hit  = rtw_cfg_i && rtw_tick_i;

    always_comb begin
        wake_o  = 1'b0;
        pend_o  = 1'b0;
        cause_o = CAUSE_NONE;
        case (state_i)
            ST_STOP1: begin
                wake_o  = deep_hit && supply_ok_i;
                pend_o  = deep_hit && !supply_ok_i;
                cause_o = CAUSE_POR;
            end
            ST_STOP2, ST_STOP3: begin
                wake_o = pin_hit || irq_hit || tmr_hit;
                if (pin_hit) begin
                    cause_o = CAUSE_PIN;
                end else if (irq_hit) begin
                    cause_o = CAUSE_IRQ;
                end else begin
                    cause_o = CAUSE_TIMER;
                end
            end
            default: begin
                wake_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/stop_dom_decode.sv
module stop_dom_decode
    import stop_ctl_pkg::*;
(
    input  pm_state_e state_i,
    input  logic      osc_keep_i,
    input  logic      rtw_cfg_i,
    output dom_ctl_t  ctl_o,
    output logic      rtw_en_o
);
    always_comb begin
        ctl_o.clk_en    = 1'b1;
        ctl_o.logic_dom = DOM_ON;
        ctl_o.ram_dom   = DOM_ON;
        ctl_o.reg_stby  = 1'b0;
        ctl_o.conv_dom  = DOM_ON;
        ctl_o.pad_hold  = 1'b0;
        ctl_o.pad_reset = 1'b0;
        ctl_o.osc_en    = 1'b1;
        ctl_o.lv_flag   = 1'b0;
        rtw_en_o        = 1'b0;
        case (state_i)
            ST_STOP1: begin
                ctl_o.clk_en    = 1'b0;
                ctl_o.logic_dom = DOM_OFF;
                ctl_o.ram_dom   = DOM_OFF;
                ctl_o.reg_stby  = 1'b1;
                ctl_o.conv_dom  = DOM_STBY;
                ctl_o.pad_reset = 1'b1;
                ctl_o.osc_en    = 1'b0;
                ctl_o.lv_flag   = 1'b1;
                rtw_en_o        = rtw_cfg_i;
            end
            ST_STOP2: begin
                ctl_o.clk_en    = 1'b0;
                ctl_o.logic_dom = DOM_OFF;
                ctl_o.ram_dom   = DOM_STBY;
                ctl_o.reg_stby  = 1'b1;
                ctl_o.conv_dom  = DOM_OFF;
                ctl_o.pad_hold  = 1'b1;
                ctl_o.osc_en    = 1'b0;
                rtw_en_o        = rtw_cfg_i;
            end
            ST_STOP3: begin
                ctl_o.clk_en    = 1'b0;
                ctl_o.logic_dom = DOM_STBY;
                ctl_o.ram_dom   = DOM_STBY;
                ctl_o.reg_stby  = 1'b1;
                ctl_o.conv_dom  = DOM_OFF;
                ctl_o.pad_hold  = 1'b1;
                ctl_o.osc_en    = osc_keep_i;
                rtw_en_o        = rtw_cfg_i;
            end
            ST_WAKE: begin
                // power back, pads released, clocks one cycle later
                ctl_o.clk_en    = 1'b0;
            end
            default: begin
                ctl_o.clk_en    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
    import stop_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req,
    input  logic               stop_en,
    input  logic [1:0]         lvl_sel,
    input  logic               lvd_en,
    input  logic               lvd_stop_en,
    input  logic               rtw_cfg,
    input  logic               osc_keep,
    input  logic               irq_en,
    input  logic               irq_pol,
    input  logic               irq_pin,
    input  logic               reset_pin_n,
    input  logic               rtw_tick,
    input  logic               supply_ok,
    output logic               clk_en,
    output logic [DOM_W-1:0]   logic_dom,
    output logic [DOM_W-1:0]   ram_dom,
    output logic               reg_stby,
    output logic [DOM_W-1:0]   conv_dom,
    output logic               pad_hold,
    output logic               pad_reset,
    output logic               rtw_en,
    output logic               osc_en,
    output logic               lv_flag,
    output logic               ill_rst,
    output logic               por_rst,
    output logic [CAUSE_W-1:0] wake_cause
);
    ctl_regs_t r_d, r_q;

    logic               illegal;
    pm_state_e          target;
    logic               wake;
    logic               pend_nx;
    logic [CAUSE_W-1:0] wcause;
    dom_ctl_t           ctl;

    stop_level_select u_sel (
        .stop_en_i     (stop_en),
        .sel_i         (lvl_sel),
        .lvd_en_i      (lvd_en),
        .lvd_stop_en_i (lvd_stop_en),
        .illegal_o     (illegal),
        .target_o      (target)
    );

    stop_wake_detect u_wake (
        .state_i       (r_q.state),
        .pend_i        (r_q.pend),
        .reset_pin_n_i (reset_pin_n),
        .irq_pin_i     (irq_pin),
        .irq_pol_i     (irq_pol),
        .irq_en_i      (irq_en),
        .rtw_tick_i    (rtw_tick),
        .rtw_cfg_i     (rtw_cfg),
        .supply_ok_i   (supply_ok),
        .wake_o        (wake),
        .pend_o        (pend_nx),
        .cause_o       (wcause)
    );

    stop_dom_decode u_dom (
        .state_i    (r_q.state),
        .osc_keep_i (osc_keep),
        .rtw_cfg_i  (rtw_cfg),
        .ctl_o      (ctl),
        .rtw_en_o   (rtw_en)
    );

    always_comb begin
        r_d           = r_q;
        r_d.ill_pulse = 1'b0;
        r_d.por_pulse = 1'b0;
        case (r_q.state)
            ST_RUN: begin
                if (stop_req) begin
                    if (illegal) begin
                        r_d.ill_pulse = 1'b1;
                        r_d.cause     = CAUSE_ILL;
                    end else begin
                        r_d.state = target;
                        r_d.pend  = 1'b0;
                    end
                end
            end
            ST_STOP1: begin
                r_d.pend = pend_nx;
                if (wake) begin
                    r_d.state     = ST_WAKE;
                    r_d.por_pulse = 1'b1;
                    r_d.cause     = wcause;
                end
            end
            ST_STOP2, ST_STOP3: begin
                if (wake) begin
                    r_d.state = ST_WAKE;
                    r_d.cause = wcause;
                end
            end
            ST_WAKE: begin
                r_d.state = ST_RUN;
                r_d.pend  = 1'b0;
            end
            default: begin
                r_d.state = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, pend: 1'b0, ill_pulse: 1'b0,
                     por_pulse: 1'b0, cause: CAUSE_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_en     = ctl.clk_en;
    assign logic_dom  = ctl.logic_dom;
    assign ram_dom    = ctl.ram_dom;
    assign reg_stby   = ctl.reg_stby;
    assign conv_dom   = ctl.conv_dom;
    assign pad_hold   = ctl.pad_hold;
    assign pad_reset  = ctl.pad_reset;
    assign osc_en     = ctl.osc_en;
    assign lv_flag    = ctl.lv_flag;
    assign ill_rst    = r_q.ill_pulse;
    assign por_rst    = r_q.por_pulse;
    assign wake_cause = r_q.cause;
endmodule

// File: rtl/stop_ctl_checker.sv
module stop_ctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       stop_en,
    input logic       lvd_en,
    input logic       lvd_stop_en,
    input logic       supply_ok,
    input logic       clk_en,
    input logic [1:0] logic_dom,
    input logic [1:0] ram_dom,
    input logic       pad_hold,
    input logic       pad_reset,
    input logic       ill_rst,
    input logic       por_rst
);
    assert_clk_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_dom != 2'd0 || pad_hold || pad_reset) |-> !clk_en);

    assert_ill_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ill_rst |-> $past(stop_req && !stop_en));

    assert_ill_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ill_rst |=> !ill_rst);

    assert_pad_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_hold && pad_reset));

    assert_deep1_lvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_reset) |-> $past(!(lvd_en && lvd_stop_en)));

    assert_deep2_lvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pad_hold) && logic_dom == 2'd2) |-> $past(!(lvd_en && lvd_stop_en)));

    assert_supply_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_reset) |-> $past(supply_ok));

    assert_por_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        por_rst |-> $past(pad_reset));

    assert_clk_after_power_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> $past(logic_dom == 2'd0 && ram_dom == 2'd0 && !pad_hold && !pad_reset));

    assert_release_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pad_hold) || $fell(pad_reset)) |-> !clk_en);
endmodule

bind stop_mode_ctrl stop_ctl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .stop_en     (stop_en),
    .lvd_en      (lvd_en),
    .lvd_stop_en (lvd_stop_en),
    .supply_ok   (supply_ok),
    .clk_en      (clk_en),
    .logic_dom   (logic_dom),
    .ram_dom     (ram_dom),
    .pad_hold    (pad_hold),
    .pad_reset   (pad_reset),
    .ill_rst     (ill_rst),
    .por_rst     (por_rst)
);

// File: tb/tb_stop_mode_ctrl.sv
`timescale 1ns/1ps
module tb_stop_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n, stop_req, stop_en, lvd_en, lvd_stop_en, rtw_cfg, osc_keep;
    logic irq_en, irq_pol, irq_pin, reset_pin_n, rtw_tick, supply_ok;
    logic [1:0] lvl_sel;
    logic clk_en, reg_stby, pad_hold, pad_reset, rtw_en, osc_en, lv_flag, ill_rst, por_rst;
    logic [1:0] logic_dom, ram_dom, conv_dom;
    logic [2:0] wake_cause;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    string       tag_q[$];
    logic [17:0] exp_q[$];
    event        push_ev;
    event        done_ev;

    always #2.5 clk = ~clk;

    stop_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_en(stop_en),
        .lvl_sel(lvl_sel), .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en),
        .rtw_cfg(rtw_cfg), .osc_keep(osc_keep), .irq_en(irq_en), .irq_pol(irq_pol),
        .irq_pin(irq_pin), .reset_pin_n(reset_pin_n), .rtw_tick(rtw_tick),
        .supply_ok(supply_ok), .clk_en(clk_en), .logic_dom(logic_dom),
        .ram_dom(ram_dom), .reg_stby(reg_stby), .conv_dom(conv_dom),
        .pad_hold(pad_hold), .pad_reset(pad_reset), .rtw_en(rtw_en), .osc_en(osc_en),
        .lv_flag(lv_flag), .ill_rst(ill_rst), .por_rst(por_rst), .wake_cause(wake_cause)
    );

    function automatic logic [17:0] pk(input logic c, input logic [1:0] lg, input logic [1:0] rm,
                                       input logic rg, input logic [1:0] cv, input logic hd,
                                       input logic pr, input logic rt, input logic os,
                                       input logic lv, input logic il, input logic po,
                                       input logic [2:0] cs);
        return {c, lg, rm, rg, cv, hd, pr, rt, os, lv, il, po, cs};
    endfunction

    function automatic logic [17:0] e_run(input logic il, input logic po, input logic [2:0] cs);
        return pk(1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, il, po, cs);
    endfunction
    function automatic logic [17:0] e_wake(input logic po, input logic [2:0] cs);
        return pk(1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, po, cs);
    endfunction
    function automatic logic [17:0] e_s1(input logic rt, input logic [2:0] cs);
        return pk(1'b0, 2'd2, 2'd2, 1'b1, 2'd1, 1'b0, 1'b1, rt, 1'b0, 1'b1, 1'b0, 1'b0, cs);
    endfunction
    function automatic logic [17:0] e_s2(input logic rt, input logic [2:0] cs);
        return pk(1'b0, 2'd2, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0, rt, 1'b0, 1'b0, 1'b0, 1'b0, cs);
    endfunction
    function automatic logic [17:0] e_s3(input logic rt, input logic os, input logic [2:0] cs);
        return pk(1'b0, 2'd1, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0, rt, os, 1'b0, 1'b0, 1'b0, cs);
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(push_ev);
            while (exp_q.size() != 0) begin
                string       t;
                logic [17:0] e;
                logic [17:0] a;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                a = {clk_en, logic_dom, ram_dom, reg_stby, conv_dom, pad_hold, pad_reset,
                     rtw_en, osc_en, lv_flag, ill_rst, por_rst, wake_cause};
                n_vec++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b", t, a, e);
                end
            end
            -> done_ev;
        end
    end

    task automatic expect_out(input string t, input logic [17:0] e);
        tag_q.push_back(t);
        exp_q.push_back(e);
        -> push_ev;
        @(done_ev);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_req();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stop_req = 1'b0; stop_en = 1'b1; lvl_sel = 2'b00;
        lvd_en = 1'b0; lvd_stop_en = 1'b0; rtw_cfg = 1'b0; osc_keep = 1'b0;
        irq_en = 1'b0; irq_pol = 1'b0; irq_pin = 1'b1; reset_pin_n = 1'b1;
        rtw_tick = 1'b0; supply_ok = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        expect_out("R3 reset state run", e_run(1'b0, 1'b0, 3'd0));

        // illegal request
        stop_en = 1'b0;
        pulse_req();
        expect_out("R1 illegal pulse", e_run(1'b1, 1'b0, 3'd5));
        tick();
        expect_out("R1 pulse one cycle", e_run(1'b0, 1'b0, 3'd5));
        stop_en = 1'b1;

        // level 3 via 01, osc kept, timer enabled
        lvl_sel = 2'b01; rtw_cfg = 1'b1; osc_keep = 1'b1;
        pulse_req();
        expect_out("R2 R6 R7 level3 sel01", e_s3(1'b1, 1'b1, 3'd5));
        lvl_sel = 2'b11;
        pulse_req();
        expect_out("R13 request in stop ignored", e_s3(1'b1, 1'b1, 3'd5));
        irq_en = 1'b1; irq_pin = 1'b0;
        tick();
        expect_out("R11 R12 irq wake cycle", e_wake(1'b0, 3'd2));
        irq_pin = 1'b1;
        tick();
        expect_out("R12 clocks back", e_run(1'b0, 1'b0, 3'd2));

        // level 3 via 00, irq disabled, reset pin wake
        lvl_sel = 2'b00; rtw_cfg = 1'b0; osc_keep = 1'b0; irq_en = 1'b0;
        pulse_req();
        expect_out("R2 R6 level3 sel00", e_s3(1'b0, 1'b0, 3'd2));
        irq_pin = 1'b0;
        tick();
        expect_out("R11 disabled irq ignored", e_s3(1'b0, 1'b0, 3'd2));
        irq_pin = 1'b1; reset_pin_n = 1'b0;
        tick();
        expect_out("R11 reset pin wake", e_wake(1'b0, 3'd3));
        reset_pin_n = 1'b1;
        tick();
        expect_out("R12 run after pin", e_run(1'b0, 1'b0, 3'd3));

        // level 2, timer wake
        lvl_sel = 2'b10; rtw_cfg = 1'b1;
        pulse_req();
        expect_out("R2 R5 level2", e_s2(1'b1, 3'd3));
        rtw_tick = 1'b1;
        tick();
        expect_out("R11 timer wake", e_wake(1'b0, 3'd4));
        rtw_tick = 1'b0;
        tick();
        expect_out("R7 rtw off in run", e_run(1'b0, 1'b0, 3'd4));

        // level 2, irq beats timer
        irq_en = 1'b1;
        pulse_req();
        expect_out("R5 level2 again", e_s2(1'b1, 3'd4));
        irq_pin = 1'b0; rtw_tick = 1'b1;
        tick();
        expect_out("R11 irq over timer", e_wake(1'b0, 3'd2));
        irq_pin = 1'b1; rtw_tick = 1'b0;
        tick();
        expect_out("R12 run after level2", e_run(1'b0, 1'b0, 3'd2));

        // level 1 with supply low, irq active-high config
        lvl_sel = 2'b11; irq_pol = 1'b1; irq_en = 1'b0; supply_ok = 1'b0;
        pulse_req();
        expect_out("R2 R4 R10 level1", e_s1(1'b1, 3'd2));
        rtw_tick = 1'b1;
        tick();
        expect_out("R9 timer ignored in level1", e_s1(1'b1, 3'd2));
        rtw_tick = 1'b0; irq_pin = 1'b0;
        tick();
        expect_out("R9 held by supply", e_s1(1'b1, 3'd2));
        irq_pin = 1'b1;
        tick();
        expect_out("R9 still held", e_s1(1'b1, 3'd2));
        supply_ok = 1'b1;
        tick();
        expect_out("R9 R10 remembered wake por", e_wake(1'b1, 3'd1));
        tick();
        expect_out("R10 por one cycle", e_run(1'b0, 1'b0, 3'd1));

        // fallback from level 1 request
        irq_pol = 1'b0; irq_en = 1'b1; lvd_en = 1'b1; lvd_stop_en = 1'b1;
        rtw_cfg = 1'b0; osc_keep = 1'b1;
        pulse_req();
        expect_out("R8 level1 falls back", e_s3(1'b0, 1'b1, 3'd1));
        irq_pin = 1'b0;
        tick();
        expect_out("R11 active-low irq wake", e_wake(1'b0, 3'd2));
        irq_pin = 1'b1;
        tick();
        expect_out("R12 run after fallback", e_run(1'b0, 1'b0, 3'd2));

        // fallback from level 2 request
        lvl_sel = 2'b10;
        pulse_req();
        expect_out("R8 level2 falls back", e_s3(1'b0, 1'b1, 3'd2));
        reset_pin_n = 1'b0;
        tick();
        expect_out("R11 pin wake from fallback", e_wake(1'b0, 3'd3));
        reset_pin_n = 1'b1;
        tick();

        // detector enabled but not in stop: level 1 kept
        lvd_stop_en = 1'b0; lvl_sel = 2'b11; rtw_cfg = 1'b0;
        pulse_req();
        expect_out("R8 level1 kept", e_s1(1'b0, 3'd3));
        reset_pin_n = 1'b0;
        tick();
        expect_out("R9 R10 pin wake level1", e_wake(1'b1, 3'd1));
        reset_pin_n = 1'b1;
        tick();
        expect_out("R10 run after level1", e_run(1'b0, 1'b0, 3'd1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule